// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block looks across a small bank of interrupt list entries and picks the one that should be delivered next. Each entry holds a two-bit state, a group bit, an 8-bit priority and a 10-bit virtual interrupt ID. An entry competes only when its state is purely pending, its group is enabled and its index lies below a count input that tells how many entries are in use. Among the entries that compete, the numerically lowest priority wins. When several share that priority, the lowest index wins.

The outcome is registered once per clock. It gives a valid flag, the winner's index, its whole entry, its priority and its ID. When no entry competes, the block reports an idle priority and the spurious ID instead. The block only reports a choice. It never rewrites entry state, and it applies no priority mask and no active-priority filtering.

Top module: `irq_pending_picker`

## Requirements
- R1: An entry competes only when its state field is 2'b01 (pending). The encodings 2'b00 (invalid), 2'b10 (active) and 2'b11 (pending and active) never compete.
- R2: An entry whose group bit is 0 never competes while `grp0_en_i` is low.
- R3: An entry whose group bit is 1 never competes while `grp1_en_i` is low.
- R4: Among competing entries, the one with the numerically lowest priority value is selected.
- R5: When competing entries share the lowest priority, the one with the lowest index is selected.
- R6: An entry with priority 8'hFF is never selected, because the search starts from the idle priority 8'hFF and a candidate must be strictly lower to replace it.
- R7: Only entries with an index strictly below `used_cnt_i` compete. A count of 0 selects nothing.
- R8: When nothing is selected, the outputs take these values: `sel_valid_o`=0, `sel_index_o`=0, `sel_prio_o`=8'hFF, `sel_id_o`=10'h3FF, and `sel_entry_o` equal to the idle entry {state 2'b00, group 0, priority 8'hFF, ID 10'h3FF}.
- R9: The outputs are registered. They reflect the inputs present at the previous rising clock edge. While `rst_ni` is low, they hold the idle values of R8.
- R10: When something is selected, `sel_entry_o` equals the winning entry bit for bit. The layout is {state[20:19], group[18], priority[17:10], ID[9:0]}, and entry i occupies bits [21*i+20 : 21*i] of `bank_i`. `sel_prio_o` and `sel_id_o` equal that entry's priority and ID fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bank_i | input | NUM_ENTRIES*21 | Packed bank of interrupt list entries |
| used_cnt_i | input | $clog2(NUM_ENTRIES+1) | Number of entries, counted from index 0, that may compete |
| grp0_en_i | input | 1 | Enable for group-0 entries |
| grp1_en_i | input | 1 | Enable for group-1 entries |
| sel_valid_o | output | 1 | An entry was selected |
| sel_index_o | output | $clog2(NUM_ENTRIES) | Index of the selected entry, 0 when none |
| sel_entry_o | output | 21 | Full selected entry, or the idle entry |
| sel_prio_o | output | 8 | Selected priority, or 8'hFF |
| sel_id_o | output | 10 | Selected ID, or the spurious ID 10'h3FF |

## Verification
Every result is due exactly one rising edge after its stimulus. That edge is the only register between the entry bank and the outputs. The bench changes inputs on a falling edge, lets one rising edge pass, and samples on the next falling edge, so every comparison lands half a period after the register has updated. One directed check samples just before that rising edge and confirms that the old result is still held. Another confirms that the idle values are present during reset.

// File: rtl/irq_pick_pkg.sv
`timescale 1ns/1ps
package irq_pick_pkg;

    localparam int ID_W   = 10;
    localparam int PRIO_W = 8;

    localparam logic [PRIO_W-1:0] IDLE_PRIO   = 8'hFF;
    localparam logic [ID_W-1:0]   SPURIOUS_ID = 10'h3FF;

    typedef enum logic [1:0] {
        ST_INVALID  = 2'b00,
        ST_PENDING  = 2'b01,
        ST_ACTIVE   = 2'b10,
        ST_PEND_ACT = 2'b11
    } lr_state_e;

    typedef struct packed {
        lr_state_e          state;
        logic               grp;
        logic [PRIO_W-1:0]  prio;
        logic [ID_W-1:0]    vid;
    } lr_entry_t;

    localparam int ENTRY_W = $bits(lr_entry_t);

    localparam lr_entry_t IDLE_ENTRY = '{
        state: ST_INVALID,
        grp:   1'b0,
        prio:  IDLE_PRIO,
        vid:   SPURIOUS_ID
    };

endpackage

// File: rtl/irq_pick_qualify.sv
`timescale 1ns/1ps
module irq_pick_qualify
    import irq_pick_pkg::*;
#(
    parameter int INDEX = 0,
    parameter int CNT_W = 5
) (
    input  lr_entry_t          entry_i,
    input  logic [CNT_W-1:0]   used_cnt_i,
    input  logic               grp0_en_i,
    input  logic               grp1_en_i,
    output logic               cand_o
);

    localparam logic [CNT_W-1:0] MY_IDX = CNT_W'(INDEX);

    logic in_range;
    logic is_pending;
    logic grp_ok;

    always_comb begin
        in_range   = MY_IDX < used_cnt_i;
        is_pending = entry_i.state == ST_PENDING;
        grp_ok     = entry_i.grp ? grp1_en_i : grp0_en_i;
        cand_o     = in_range && is_pending && grp_ok;
    end

endmodule

// File: rtl/irq_pick_select.sv
`timescale 1ns/1ps
module irq_pick_select
    import irq_pick_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  lr_entry_t                          bank_i [NUM_ENTRIES],
    input  logic [NUM_ENTRIES-1:0]             cand_i,
    output logic                               found_o,
    output logic [$clog2(NUM_ENTRIES)-1:0]     idx_o,
    output lr_entry_t                          entry_o
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);

    logic [PRIO_W-1:0] best_prio;

    // Linear scan. A strict compare keeps the earliest index on a tie, and
    // starting from the idle priority shuts out entries at 8'hFF.
    always_comb begin
        best_prio = IDLE_PRIO;
        found_o   = 1'b0;
        idx_o     = '0;
        entry_o   = IDLE_ENTRY;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (cand_i[i] && (bank_i[i].prio < best_prio)) begin
                best_prio = bank_i[i].prio;
                found_o   = 1'b1;
                idx_o     = IDX_W'(i);
                entry_o   = bank_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_pending_picker.sv
`timescale 1ns/1ps
module irq_pending_picker
    import irq_pick_pkg::*;
#(
    parameter int NUM_ENTRIES = 16
) (
    input  logic                                   clk_i,
    input  logic                                   rst_ni,
    input  logic [NUM_ENTRIES*ENTRY_W-1:0]         bank_i,
    input  logic [$clog2(NUM_ENTRIES+1)-1:0]       used_cnt_i,
    input  logic                                   grp0_en_i,
    input  logic                                   grp1_en_i,
    output logic                                   sel_valid_o,
    output logic [$clog2(NUM_ENTRIES)-1:0]         sel_index_o,
    output logic [ENTRY_W-1:0]                     sel_entry_o,
    output logic [PRIO_W-1:0]                      sel_prio_o,
    output logic [ID_W-1:0]                        sel_id_o
);

    localparam int IDX_W = $clog2(NUM_ENTRIES);
    localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

    typedef struct packed {
        logic              valid;
        logic [IDX_W-1:0]  idx;
        lr_entry_t         entry;
    } pick_t;

    localparam pick_t PICK_IDLE = '{valid: 1'b0, idx: '0, entry: IDLE_ENTRY};

    lr_entry_t              bank [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] cand;
    logic                   found;
    logic [IDX_W-1:0]       win_idx;
    lr_entry_t              win_entry;
    pick_t                  pick_d, pick_q;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        assign bank[g] = lr_entry_t'(bank_i[g*ENTRY_W +: ENTRY_W]);

        irq_pick_qualify #(
            .INDEX (g),
            .CNT_W (CNT_W)
        ) u_qualify (
            .entry_i    (bank[g]),
            .used_cnt_i (used_cnt_i),
            .grp0_en_i  (grp0_en_i),
            .grp1_en_i  (grp1_en_i),
            .cand_o     (cand[g])
        );
    end

    irq_pick_select #(
        .NUM_ENTRIES (NUM_ENTRIES)
    ) u_select (
        .bank_i  (bank),
        .cand_i  (cand),
        .found_o (found),
        .idx_o   (win_idx),
        .entry_o (win_entry)
    );

    always_comb begin
        pick_d       = PICK_IDLE;
        pick_d.valid = found;
        if (found) begin
            pick_d.idx   = win_idx;
            pick_d.entry = win_entry;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pick_q <= PICK_IDLE;
        end else begin
            pick_q <= pick_d;
        end
    end

    assign sel_valid_o = pick_q.valid;
    assign sel_index_o = pick_q.idx;
    assign sel_entry_o = pick_q.entry;
    assign sel_prio_o  = pick_q.entry.prio;
    assign sel_id_o    = pick_q.entry.vid;

    // Checks on the registered result against the inputs of the prior edge.
    assert_only_pending_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_valid_o |-> (pick_q.entry.state == ST_PENDING));

    assert_grp0_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_valid_o && !pick_q.entry.grp) |-> $past(grp0_en_i));

    assert_grp1_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_valid_o && pick_q.entry.grp) |-> $past(grp1_en_i));

    assert_never_idle_prio_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_valid_o |-> (sel_prio_o != IDLE_PRIO));

    assert_within_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_valid_o |-> (CNT_W'(sel_index_o) < $past(used_cnt_i)));

    assert_idle_outputs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sel_valid_o |-> (sel_prio_o == IDLE_PRIO && sel_id_o == SPURIOUS_ID
                          && sel_index_o == '0));

endmodule

// File: tb/irq_pending_picker_bench.sv
`timescale 1ns/1ps
module irq_pending_picker_bench;

    localparam int NUM   = 16;
    localparam int EW    = 21;
    localparam logic [20:0] IDLE_E = {2'b00, 1'b0, 8'hFF, 10'h3FF};
    localparam logic [20:0] NONE   = 21'd0;

    typedef struct packed {
        logic [4:0]   cnt;
        logic         en0;
        logic         en1;
        logic [83:0]  ents;      // {e3, e2, e1, e0}
        logic         exp_valid;
        logic [3:0]   exp_idx;
        logic [7:0]   exp_prio;
        logic [9:0]   exp_id;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        // R1 R4: lowest priority among pending, active entry with lower value skipped
        '{5'd4, 1'b1, 1'b1,
          {{2'b01,1'b1,8'h30,10'd13},{2'b10,1'b1,8'h05,10'd12},
           {2'b01,1'b0,8'h20,10'd11},{2'b01,1'b1,8'h40,10'd10}},
          1'b1, 4'd1, 8'h20, 10'd11},
        // R2: group 0 disabled
        '{5'd4, 1'b0, 1'b1,
          {{2'b01,1'b1,8'h30,10'd13},{2'b10,1'b1,8'h05,10'd12},
           {2'b01,1'b0,8'h20,10'd11},{2'b01,1'b1,8'h40,10'd10}},
          1'b1, 4'd3, 8'h30, 10'd13},
        // R3: group 1 disabled
        '{5'd4, 1'b1, 1'b0,
          {{2'b01,1'b1,8'h10,10'd13},{2'b10,1'b1,8'h05,10'd12},
           {2'b01,1'b0,8'h20,10'd11},{2'b01,1'b1,8'h08,10'd10}},
          1'b1, 4'd1, 8'h20, 10'd11},
        // R5: tie goes to lowest index
        '{5'd4, 1'b1, 1'b1,
          {NONE,{2'b01,1'b1,8'h50,10'd22},
           {2'b01,1'b1,8'h50,10'd21},{2'b01,1'b1,8'h50,10'd20}},
          1'b1, 4'd0, 8'h50, 10'd20},
        // R7: entry 2 beyond count
        '{5'd2, 1'b1, 1'b1,
          {NONE,{2'b01,1'b1,8'h10,10'd32},
           {2'b01,1'b1,8'h70,10'd31},{2'b01,1'b1,8'h60,10'd30}},
          1'b1, 4'd0, 8'h60, 10'd30},
        // R6 R8: only priority FF pending, nothing selected
        '{5'd4, 1'b1, 1'b1,
          {{2'b01,1'b1,8'hFF,10'd3},{2'b01,1'b0,8'hFF,10'd2},
           {2'b01,1'b1,8'hFF,10'd1},{2'b01,1'b0,8'hFF,10'd0}},
          1'b0, 4'd0, 8'hFF, 10'h3FF},
        // R1: invalid, active, pending+active skipped
        '{5'd4, 1'b1, 1'b1,
          {{2'b01,1'b0,8'h90,10'd40},{2'b00,1'b0,8'h03,10'd41},
           {2'b10,1'b1,8'h02,10'd42},{2'b11,1'b1,8'h01,10'd43}},
          1'b1, 4'd3, 8'h90, 10'd40},
        // R7 R8: count zero
        '{5'd0, 1'b1, 1'b1,
          {NONE,NONE,NONE,{2'b01,1'b1,8'h01,10'd44}},
          1'b0, 4'd0, 8'hFF, 10'h3FF}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM*EW-1:0]   bank = '0;
    logic [4:0]          cnt = '0;
    logic                en0 = 1'b0;
    logic                en1 = 1'b0;
    logic                sel_valid;
    logic [3:0]          sel_index;
    logic [20:0]         sel_entry;
    logic [7:0]          sel_prio;
    logic [9:0]          sel_id;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    irq_pending_picker #(.NUM_ENTRIES(NUM)) u_irq_pending_picker (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bank_i      (bank),
        .used_cnt_i  (cnt),
        .grp0_en_i   (en0),
        .grp1_en_i   (en1),
        .sel_valid_o (sel_valid),
        .sel_index_o (sel_index),
        .sel_entry_o (sel_entry),
        .sel_prio_o  (sel_prio),
        .sel_id_o    (sel_id)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic v, input logic [3:0] idx,
                             input logic [20:0] ent);
        check(req, "valid", 32'(sel_valid), 32'(v));
        check(req, "index", 32'(sel_index), 32'(idx));
        check(req, "entry", 32'(sel_entry), 32'(ent));
        check(req, "prio",  32'(sel_prio),  32'(ent[17:10]));
        check(req, "id",    32'(sel_id),    32'(ent[9:0]));
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #80000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R9: idle values during reset even with a qualifying entry present
        bank[20:0] = {2'b01, 1'b1, 8'h01, 10'd7};
        cnt = 5'd16; en0 = 1'b1; en1 = 1'b1;
        step();
        check_all("R9 reset", 1'b0, 4'd0, IDLE_E);
        rst_n = 1'b1;
        bank = '0;
        step();

        for (int v = 0; v < NV; v++) begin
            logic [20:0] exp_e;
            @(negedge clk);
            bank = '0;
            bank[83:0] = VECS[v].ents;
            cnt = VECS[v].cnt;
            en0 = VECS[v].en0;
            en1 = VECS[v].en1;
            step();
            exp_e = VECS[v].exp_valid ? VECS[v].ents[VECS[v].exp_idx*EW +: EW] : IDLE_E;
            check($sformatf("R10 vec%0d", v), "valid", 32'(sel_valid), 32'(VECS[v].exp_valid));
            check($sformatf("R4 vec%0d", v), "index", 32'(sel_index), 32'(VECS[v].exp_idx));
            check($sformatf("R10 vec%0d", v), "prio", 32'(sel_prio), 32'(VECS[v].exp_prio));
            check($sformatf("R8 vec%0d", v), "id", 32'(sel_id), 32'(VECS[v].exp_id));
            check($sformatf("R10 vec%0d", v), "entry", 32'(sel_entry), 32'(exp_e));
        end

        // R7: top entry selectable only with full count
        bank = '0;
        bank[15*EW +: EW] = {2'b01, 1'b0, 8'h22, 10'd99};
        cnt = 5'd16;
        step();
        check_all("R7 last entry", 1'b1, 4'd15, {2'b01, 1'b0, 8'h22, 10'd99});
        cnt = 5'd15;
        step();
        check_all("R7 count 15", 1'b0, 4'd0, IDLE_E);

        // R9: result still old just before the edge, new one after it
        cnt = 5'd16;
        step();
        bank[3*EW +: EW] = {2'b01, 1'b1, 8'h11, 10'd55};
        #1;
        check("R9 before edge", "index", 32'(sel_index), 32'd15);
        @(negedge clk);
        check_all("R9 after edge", 1'b1, 4'd3, {2'b01, 1'b1, 8'h11, 10'd55});

        // R6: priority FE wins over FF
        bank = '0;
        bank[0 +: EW]  = {2'b01, 1'b1, 8'hFF, 10'd60};
        bank[EW +: EW] = {2'b01, 1'b1, 8'hFE, 10'd61};
        step();
        check_all("R6 FE vs FF", 1'b1, 4'd1, {2'b01, 1'b1, 8'hFE, 10'd61});

        finish_run();
    end

endmodule